// File: doc/BRIEF.md
# Word-Wide Arithmetic, Logic and Shift Unit

This block computes one data-path operation per clock cycle on 32-bit words. The operations are addition and subtraction, with carry-in and reverse forms, bitwise logic, move and inverted move, four barrel shifts, and a count of the leading zeros. A 5-bit opcode selects the operation. The result and four condition flags are captured in registers on the rising clock edge. The flags are negative, zero, carry and overflow.

The second operand is either the `opb_i` word or, when `use_imm_i` is high, an unsigned 12-bit constant widened with zeros. For the shift opcodes, `opa_i` is the value that is shifted. The shift distance is `imm_i[4:0]` in the immediate form and `opb_i[7:0]` in the register form.

The flags change only when `set_flags_i` is high. Otherwise they keep their previous values. Because of this, a sequence of add-with-carry or subtract-with-carry operations can carry a borrow or carry from one word to the next. This lets the unit process operands wider than 32 bits, least significant word first. The flag register acts as the unit's only state between operations.

Top module: `alu_core`

## Requirements
- R1: Opcode 0x00 gives A+B and opcode 0x01 gives A+B+Cstored. C is the carry out and V is the signed overflow.
- R2: Opcode 0x02 gives A-B, opcode 0x03 gives A-B-(1-Cstored) and opcode 0x04 gives B-A. For these, C=1 means no borrow and V is the signed overflow.
- R3: Chained with-carry operations across consecutive cycles give the correct wide sum or difference. The examples are a 64-bit add and a 96-bit subtract, each done least significant word first.
- R4: The logic opcodes are 0x05 AND, 0x06 OR, 0x07 XOR, 0x08 A AND NOT B and 0x09 A OR NOT B.
- R5: Opcode 0x0A passes B through unchanged. Opcode 0x0B outputs NOT B, so 0x0000000F gives 0xFFFFFFF0.
- R6: The shift opcodes are 0x0C arithmetic right, 0x0D logical left, 0x0E logical right and 0x0F rotate right, applied to A. C takes the last bit shifted out, or bit 31 of the result for rotate. With `use_imm_i`=1 the distance is `imm_i[4:0]`.
- R7: With `use_imm_i`=0 the shift distance is `opb_i[7:0]` only. A distance of 32 or more gives 0 for the logical shifts and the sign fill for the arithmetic shift. At exactly 32, C is A[0] for a left shift and A[31] for a right shift; beyond 32, C is 0 for the logical shifts. Rotate uses the distance modulo 32, and a non-zero multiple of 32 leaves A unchanged with C=A[31].
- R8: A shift distance of 0 leaves both the value and C unchanged.
- R9: Opcode 0x10 returns the number of zero bits above the highest set bit of A, and returns 32 when A is 0.
- R10: The flags are written only when `set_flags_i`=1. Otherwise all four keep their values.
- R11: N is result bit 31 and Z is 1 exactly when the result is 0. The logic, move and count opcodes leave C and V unchanged, and the shift opcodes leave V unchanged.
- R12: With `use_imm_i`=1, the non-shift opcodes take B from `imm_i` zero-extended to 32 bits, covering the range 0 to 4095, and ignore `opb_i`.
- R13: The result and flags appear one rising edge after the inputs. A synchronous `rst` clears the result and all flags.
- R14: Opcodes 0x11 to 0x1F give a zero result and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 5 | Operation select |
| opa_i | input | 32 | Operand A and the value that is shifted |
| opb_i | input | 32 | Operand B and the register shift distance (low byte) |
| use_imm_i | input | 1 | Selects the immediate as operand B or as the shift distance |
| imm_i | input | 12 | Unsigned immediate |
| set_flags_i | input | 1 | Enables the flag update |
| result_o | output | 32 | Registered result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
The bench uses the default parameters: a 32-bit word, a 12-bit immediate and an 8-bit register shift field. Because the shift field is 8 bits wide, the bench can apply register distances of 32, 36, 40 and 64. These reach the saturated shifts and the modulo-32 rotate. An upper byte in `opb_i` shows that only the low byte is used as the distance. The 12-bit immediate lets the bench apply 4095 against a non-zero `opb_i`, which shows the zero extension. The 32-bit word allows a three-word chained subtract whose borrow passes through two all-ones words.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD = 5'h00,
        OP_ADC = 5'h01,
        OP_SUB = 5'h02,
        OP_SBC = 5'h03,
        OP_RSB = 5'h04,
        OP_AND = 5'h05,
        OP_ORR = 5'h06,
        OP_EOR = 5'h07,
        OP_BIC = 5'h08,
        OP_ORN = 5'h09,
        OP_MOV = 5'h0A,
        OP_MVN = 5'h0B,
        OP_ASR = 5'h0C,
        OP_LSL = 5'h0D,
        OP_LSR = 5'h0E,
        OP_ROR = 5'h0F,
        OP_CLZ = 5'h10
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    localparam logic [4:0] OP_LAST_VALID = 5'h10;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              ovf_o
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
        sum_o    = wide_sum[DATA_W-1:0];
        cout_o   = wide_sum[DATA_W];
        // signed overflow: addends agree in sign, sum disagrees
        ovf_o    = (x_i[DATA_W-1] == y_i[DATA_W-1]) &&
                   (sum_o[DATA_W-1] != x_i[DATA_W-1]);
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  shift_kind_e       kind_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] ext_left;
    logic [EXT_W-1:0] ext_right;
    logic [EXT_W-1:0] ext_arith;
    logic [SH_W-1:0]  rot_amt;
    logic [DATA_W-1:0] rot_val;

    always_comb begin
        // extra bit beside the word catches the last bit shifted out
        ext_left  = {1'b0, val_i} << amt_i;
        ext_right = {val_i, 1'b0} >> amt_i;
        ext_arith = EXT_W'($signed({val_i, 1'b0}) >>> amt_i);
        rot_amt   = amt_i[SH_W-1:0];
        if (rot_amt == '0) begin
            rot_val = val_i;
        end else begin
            rot_val = (val_i >> rot_amt) | (val_i << (SH_W'(DATA_W - 1) - rot_amt + 1'b1));
        end
    end

    always_comb begin
        res_o  = val_i;
        cout_o = cin_i;
        if (amt_i != '0) begin
            unique case (kind_i)
                SH_LSL: begin
                    res_o  = ext_left[DATA_W-1:0];
                    cout_o = ext_left[DATA_W];
                end
                SH_LSR: begin
                    res_o  = ext_right[DATA_W:1];
                    cout_o = ext_right[0];
                end
                SH_ASR: begin
                    res_o  = ext_arith[DATA_W:1];
                    cout_o = ext_arith[0];
                end
                SH_ROR: begin
                    res_o  = rot_val;
                    cout_o = rot_val[DATA_W-1];
                end
                default: begin
                    res_o  = val_i;
                    cout_o = cin_i;
                end
            endcase
        end
    end

    // R8: zero distance passes value and carry straight through
    always_comb begin
        if (!$isunknown({amt_i, val_i, cin_i}) && amt_i == '0) begin
            p_zero_amt_pass_r8: assert (res_o == val_i && cout_o == cin_i);
        end
    end

endmodule

// File: rtl/alu_lzc.sv
module alu_lzc #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] val_i,
    output logic [$clog2(DATA_W):0] cnt_o
);
    localparam int CNT_W = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0][CNT_W-1:0] cand;

    // each bit position proposes the count it would give if it were the top set bit
    for (genvar g = 0; g < DATA_W; g++) begin : g_cand
        assign cand[g] = CNT_W'(DATA_W - 1 - g);
    end

    always_comb begin
        cnt_o = CNT_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            if (val_i[i]) begin
                cnt_o = cand[i];
            end
        end
    end

    // R9: full count only for an all-zero word
    always_comb begin
        if (!$isunknown(val_i)) begin
            p_full_count_r9: assert ((val_i == '0) == (cnt_o == CNT_W'(DATA_W)));
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12,
    parameter int AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              use_imm_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              set_flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_c_o,
    output logic              flag_v_o
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int CNT_W = SH_W + 1;

    alu_op_e          op;
    alu_flags_t       flags_q, flags_d, flags_calc;
    logic [DATA_W-1:0] result_d;
    logic [DATA_W-1:0] opnd_b;
    logic [AMT_W-1:0]  sh_amt;
    logic             op_valid;

    logic [DATA_W-1:0] add_x, add_y, add_sum;
    logic             add_cin, add_cout, add_ovf;

    shift_kind_e       sh_kind;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic [CNT_W-1:0]  lz_cnt;

    assign op       = alu_op_e'(op_i);
    assign op_valid = (op_i <= OP_LAST_VALID);

    // operand B and shift distance selection
    always_comb begin
        opnd_b = use_imm_i ? {{(DATA_W-IMM_W){1'b0}}, imm_i} : opb_i;
        sh_amt = use_imm_i ? {{(AMT_W-SH_W){1'b0}}, imm_i[SH_W-1:0]}
                           : opb_i[AMT_W-1:0];
    end

    // adder operand steering
    always_comb begin
        add_x   = opa_i;
        add_y   = opnd_b;
        add_cin = 1'b0;
        unique case (op)
            OP_ADC: add_cin = flags_q.c;
            OP_SUB: begin
                add_y   = ~opnd_b;
                add_cin = 1'b1;
            end
            OP_SBC: begin
                add_y   = ~opnd_b;
                add_cin = flags_q.c;
            end
            OP_RSB: begin
                add_x   = opnd_b;
                add_y   = ~opa_i;
                add_cin = 1'b1;
            end
            default: add_cin = 1'b0;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_LSL:  sh_kind = SH_LSL;
            OP_LSR:  sh_kind = SH_LSR;
            OP_ASR:  sh_kind = SH_ASR;
            default: sh_kind = SH_ROR;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .x_i    (add_x),
        .y_i    (add_y),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    alu_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shifter (
        .val_i  (opa_i),
        .amt_i  (sh_amt),
        .kind_i (sh_kind),
        .cin_i  (flags_q.c),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    alu_lzc #(.DATA_W(DATA_W)) u_lzc (
        .val_i (opa_i),
        .cnt_o (lz_cnt)
    );

    // result and candidate flags
    always_comb begin
        result_d   = '0;
        flags_calc = flags_q;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB: begin
                result_d     = add_sum;
                flags_calc.c = add_cout;
                flags_calc.v = add_ovf;
            end
            OP_AND: result_d = opa_i & opnd_b;
            OP_ORR: result_d = opa_i | opnd_b;
            OP_EOR: result_d = opa_i ^ opnd_b;
            OP_BIC: result_d = opa_i & ~opnd_b;
            OP_ORN: result_d = opa_i | ~opnd_b;
            OP_MOV: result_d = opnd_b;
            OP_MVN: result_d = ~opnd_b;
            OP_ASR, OP_LSL, OP_LSR, OP_ROR: begin
                result_d     = sh_res;
                flags_calc.c = sh_cout;
            end
            OP_CLZ: result_d = {{(DATA_W-CNT_W){1'b0}}, lz_cnt};
            default: result_d = '0;
        endcase
        flags_calc.n = result_d[DATA_W-1];
        flags_calc.z = (result_d == '0);
        flags_d = (set_flags_i && op_valid) ? flags_calc : flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            flags_q  <= '0;
        end else begin
            result_o <= result_d;
            flags_q  <= flags_d;
        end
    end

    assign flag_n_o = flags_q.n;
    assign flag_z_o = flags_q.z;
    assign flag_c_o = flags_q.c;
    assign flag_v_o = flags_q.v;

    p_reset_clears_r13: assert property (@(posedge clk)
        rst |=> (result_o == '0 && {flag_n_o, flag_z_o, flag_c_o, flag_v_o} == 4'b0000));

    p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !set_flags_i |=> $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o}));

    p_nz_follow_r11: assert property (@(posedge clk) disable iff (rst)
        (set_flags_i && op_i <= OP_LAST_VALID) |=>
            (flag_n_o == result_o[DATA_W-1] && flag_z_o == (result_o == '0)));

    p_logic_keeps_cv_r11: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 5'h05 && op_i <= 5'h0B) |=> ($stable(flag_c_o) && $stable(flag_v_o)));

    p_shift_keeps_v_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 5'h0C && op_i <= 5'h0F) |=> $stable(flag_v_o));

    p_undef_zero_r14: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_LAST_VALID) |=>
            (result_o == '0 && $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o})));

endmodule

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  op;
    logic [31:0] a, b;
    logic        use_imm;
    logic [11:0] imm;
    logic        sf;
    logic [31:0] result;
    logic        fn, fz, fc, fv;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    alu_core u0 (
        .clk(clk), .rst(rst), .op_i(op), .opa_i(a), .opb_i(b),
        .use_imm_i(use_imm), .imm_i(imm), .set_flags_i(sf),
        .result_o(result), .flag_n_o(fn), .flag_z_o(fz),
        .flag_c_o(fc), .flag_v_o(fv)
    );

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic chkf(input string req, input logic [3:0] exp);
        checks++;
        if ({fn, fz, fc, fv} !== exp) begin
            failures++;
            $display("FAIL %s flags actual=%04b expected=%04b", req, {fn, fz, fc, fv}, exp);
        end
    endtask

    task automatic chkc(input string req, input logic exp);
        checks++;
        if (fc !== exp) begin
            failures++;
            $display("FAIL %s carry actual=%0b expected=%0b", req, fc, exp);
        end
    endtask

    // drive at falling edge, sample just after the capturing rising edge
    task automatic run(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic ui, input logic [11:0] im, input logic s);
        @(negedge clk);
        op = o; a = x; b = y; use_imm = ui; imm = im; sf = s;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
        chk32("R13 reset result", result, 32'h0);
        chkf("R13 reset flags", 4'b0000);
    endtask

    task automatic t_add();
        run(5'h00, 32'h7FFFFFFF, 32'h1, 0, 0, 1);
        chk32("R1 add overflow", result, 32'h80000000);
        chkf("R1 add overflow", 4'b1001);
        run(5'h00, 32'hFFFFFFFF, 32'h1, 0, 0, 1);
        chk32("R1 add carry", result, 32'h0);
        chkf("R1 add carry", 4'b0110);
        run(5'h01, 32'd5, 32'd6, 0, 0, 1);
        chk32("R1 adc uses carry", result, 32'd12);
        chkf("R1 adc flags", 4'b0000);
    endtask

    task automatic t_sub();
        run(5'h02, 32'd5, 32'd5, 0, 0, 1);
        chk32("R2 sub equal", result, 32'h0);
        chkf("R2 sub equal", 4'b0110);
        run(5'h02, 32'd3, 32'd5, 0, 0, 1);
        chk32("R2 sub borrow", result, 32'hFFFFFFFE);
        chkf("R2 sub borrow", 4'b1000);
        run(5'h02, 32'h80000000, 32'h1, 0, 0, 1);
        chk32("R2 sub overflow", result, 32'h7FFFFFFF);
        chkf("R2 sub overflow", 4'b0011);
        run(5'h04, 32'h10, 32'h100, 0, 0, 1);
        chk32("R2 rsb", result, 32'hF0);
        chkf("R2 rsb", 4'b0010);
    endtask

    task automatic t_chain();
        run(5'h02, 32'h0, 32'h1, 0, 0, 1);
        chk32("R3 sub96 low", result, 32'hFFFFFFFF);
        run(5'h03, 32'h0, 32'h0, 0, 0, 1);
        chk32("R3 sub96 mid", result, 32'hFFFFFFFF);
        run(5'h03, 32'h1, 32'h0, 0, 0, 1);
        chk32("R3 sub96 high", result, 32'h0);
        chkf("R3 sub96 final flags", 4'b0110);
        run(5'h00, 32'hFFFFFFFF, 32'h1, 0, 0, 1);
        chk32("R3 add64 low", result, 32'h0);
        run(5'h01, 32'h1, 32'h2, 0, 0, 1);
        chk32("R3 add64 high", result, 32'h4);
    endtask

    task automatic t_hold();
        run(5'h02, 32'd5, 32'd5, 0, 0, 1);
        run(5'h00, 32'h7FFFFFFF, 32'h1, 0, 0, 0);
        chk32("R10 no-set result", result, 32'h80000000);
        chkf("R10 flags held", 4'b0110);
        run(5'h03, 32'd10, 32'd3, 0, 0, 0);
        chk32("R10 sbc with held carry", result, 32'd7);
        chkf("R10 flags held after sbc", 4'b0110);
    endtask

    task automatic t_logic();
        run(5'h00, 32'h7FFFFFFF, 32'h1, 0, 0, 1);
        run(5'h05, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 0, 1);
        chk32("R4 and", result, 32'h00F000F0);
        chkf("R11 and keeps C V", 4'b0001);
        run(5'h02, 32'd5, 32'd5, 0, 0, 1);
        run(5'h06, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 0, 1);
        chk32("R4 orr", result, 32'hFFF0FFF0);
        chkf("R11 orr keeps C V", 4'b1010);
        run(5'h07, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 0, 1);
        chk32("R4 eor", result, 32'hFF00FF00);
        run(5'h08, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 0, 1);
        chk32("R4 bic", result, 32'hF000F000);
        run(5'h09, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 0, 1);
        chk32("R4 orn", result, 32'hF0FFF0FF);
        run(5'h05, 32'hF0F0F0F0, 32'h0F0F0F0F, 0, 0, 1);
        chkf("R11 zero result", 4'b0110);
    endtask

    task automatic t_move();
        run(5'h0A, 32'h0, 32'h12345678, 0, 0, 1);
        chk32("R5 mov", result, 32'h12345678);
        run(5'h0B, 32'h0, 32'h0000000F, 0, 0, 1);
        chk32("R5 mvn", result, 32'hFFFFFFF0);
        chkf("R11 mvn flags", 4'b1010);
    endtask

    task automatic t_shift_imm();
        run(5'h0D, 32'h80000001, 32'hDEADBEEF, 1, 12'h3E1, 1);
        chk32("R6 lsl imm", result, 32'h2);
        chkc("R6 lsl imm", 1'b1);
        run(5'h0E, 32'h3, 32'h0, 1, 12'd1, 1);
        chk32("R6 lsr imm", result, 32'h1);
        chkc("R6 lsr imm", 1'b1);
        run(5'h0C, 32'h80000000, 32'h0, 1, 12'd4, 1);
        chk32("R6 asr imm", result, 32'hF8000000);
        chkc("R6 asr imm", 1'b0);
        run(5'h0F, 32'h1, 32'h0, 1, 12'd1, 1);
        chk32("R6 ror imm", result, 32'h80000000);
        chkc("R6 ror imm", 1'b1);
    endtask

    task automatic t_shift_reg();
        run(5'h0D, 32'h1, 32'hFFFFFF01, 0, 0, 1);
        chk32("R7 low byte only", result, 32'h2);
        run(5'h0D, 32'h1, 32'h00000120, 0, 0, 1);
        chk32("R7 lsl 32", result, 32'h0);
        chkc("R7 lsl 32", 1'b1);
        run(5'h0E, 32'h80000000, 32'h20, 0, 0, 1);
        chk32("R7 lsr 32", result, 32'h0);
        chkc("R7 lsr 32", 1'b1);
        run(5'h0E, 32'hFFFFFFFF, 32'h40, 0, 0, 1);
        chk32("R7 lsr 64", result, 32'h0);
        chkc("R7 lsr 64", 1'b0);
        run(5'h0C, 32'h80000000, 32'h28, 0, 0, 1);
        chk32("R7 asr 40", result, 32'hFFFFFFFF);
        chkc("R7 asr 40", 1'b1);
        run(5'h0F, 32'h12345678, 32'h24, 0, 0, 1);
        chk32("R7 ror 36", result, 32'h81234567);
        chkc("R7 ror 36", 1'b1);
        run(5'h0F, 32'h80000001, 32'h20, 0, 0, 1);
        chk32("R7 ror 32", result, 32'h80000001);
        chkc("R7 ror 32", 1'b1);
    endtask

    task automatic t_shift_zero();
        run(5'h02, 32'd5, 32'd5, 0, 0, 1);
        run(5'h0D, 32'h80000001, 32'h00000100, 0, 0, 1);
        chk32("R8 zero distance value", result, 32'h80000001);
        chkc("R8 zero distance carry 1", 1'b1);
        run(5'h02, 32'd3, 32'd5, 0, 0, 1);
        run(5'h0E, 32'h00000003, 32'h0, 1, 12'h0, 1);
        chk32("R8 zero imm value", result, 32'h3);
        chkc("R8 zero imm carry 0", 1'b0);
    endtask

    task automatic t_clz();
        run(5'h10, 32'h0, 32'h0, 0, 0, 1);
        chk32("R9 clz zero", result, 32'd32);
        run(5'h10, 32'h1, 32'h0, 0, 0, 1);
        chk32("R9 clz one", result, 32'd31);
        run(5'h10, 32'h80000000, 32'h0, 0, 0, 1);
        chk32("R9 clz top", result, 32'd0);
        chkf("R9 clz zero result flags", 4'b0100);
        run(5'h10, 32'h00010000, 32'h0, 0, 0, 1);
        chk32("R9 clz mid", result, 32'd15);
    endtask

    task automatic t_imm();
        run(5'h00, 32'h1, 32'hDEADBEEF, 1, 12'hFFF, 1);
        chk32("R12 add imm 4095", result, 32'h00001000);
        run(5'h02, 32'h0, 32'hDEADBEEF, 1, 12'h001, 1);
        chk32("R12 sub imm", result, 32'hFFFFFFFF);
        chkf("R12 sub imm flags", 4'b1000);
    endtask

    task automatic t_undef();
        run(5'h02, 32'd5, 32'd5, 0, 0, 1);
        run(5'h1F, 32'h1234, 32'h5678, 0, 0, 1);
        chk32("R14 undefined result", result, 32'h0);
        chkf("R14 undefined flags", 4'b0110);
        run(5'h11, 32'hFFFFFFFF, 32'h1, 0, 0, 1);
        chkf("R14 undefined 0x11 flags", 4'b0110);
    endtask

    task automatic t_reset_mid();
        run(5'h00, 32'h7FFFFFFF, 32'h1, 0, 0, 1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk32("R13 mid reset result", result, 32'h0);
        chkf("R13 mid reset flags", 4'b0000);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; op = 5'h0; a = '0; b = '0; use_imm = 1'b0; imm = '0; sf = 1'b0;
        t_reset();
        t_add();
        t_sub();
        t_chain();
        t_hold();
        t_logic();
        t_move();
        t_shift_imm();
        t_shift_reg();
        t_shift_zero();
        t_clz();
        t_imm();
        t_undef();
        t_reset_mid();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule